// File: doc/BRIEF.md
# Quad-Channel Double-Buffered DAC Register Bank

This block is the digital front end of a four-channel, 14-bit digital-to-analog converter. A host writes through a byte-wide parallel port: three address lines pick a channel or all channels at once, a byte-select line picks the low or the high half of the code, and a write strobe qualified by an active-low chip select commits the byte. Each channel therefore fills its 14-bit staging register in two byte writes.

Behind every staging register sits an output latch, and the latch drives that channel's code to the converter. An active-low load control moves staged values into the latches. A one-cycle low pulse updates all four channels on the same edge. Holding the control low makes each latch follow its staging register, so a channel's output changes on every byte written to it. In that mode a half-written code is visible between the two bytes.

All control inputs are sampled on the rising edge of `clk_i`. The write strobe acts on its rising edge only.

Top module: `dac_bank`

## Requirements
- R1: Asserting `rst_ni` low clears every staging register and every output latch to code 0. All four `code_o` fields read 0 until the first load after reset.
- R2: With `addr_i[2]`=0, the value of `addr_i[1:0]` (0, 1, 2, 3) selects channel 0, 1, 2 or 3. Only that channel's staging register changes.
- R3: With `addr_i[2]`=1, the write goes to all four staging registers, whatever the value of `addr_i[1:0]`.
- R4: With `hi_byte_i`=0, `data_i[7:0]` is written to code bits 7:0. With `hi_byte_i`=1, `data_i[5:0]` is written to code bits 13:8 and `data_i[7:6]` is ignored. The other half of the code is kept in both cases.
- R5: A write occurs once, on a clock edge where `wr_i` is 1 and was 0 at the previous edge, and only while `cs_ni` is 0. Keeping `wr_i` high causes no further writes. A strobe given while `cs_ni` is 1 changes nothing.
- R6: While `ldac_ni` is 1, the output latches keep their value, even when staging registers are written.
- R7: A single cycle with `ldac_ni`=0 copies all four staging registers into their latches on the same edge.
- R8: While `ldac_ni` is held at 0, each latch follows its staging register on the edge of every write. After only one of the two bytes is written, the output shows that partly updated code.
- R9: When a load and a write to the same channel fall on the same edge, the latch takes the value just written.
- R10: `code_o[14*k +: 14]` is the output code of channel k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| wr_i | input | 1 | Write strobe; acts on its rising edge |
| addr_i | input | 3 | Channel address; bit 2 selects broadcast |
| hi_byte_i | input | 1 | Byte select: 0 = low 8 bits, 1 = high 6 bits |
| data_i | input | 8 | Write data byte |
| ldac_ni | input | 1 | Active-low load control for the output latches |
| code_o | output | 56 | Four 14-bit output codes, channel 0 in the lowest bits |

## Verification
The two functions that can meet on one edge are a staging write and a load into the latches. The bench provokes this by raising the write strobe and dropping `ldac_ni` in the same cycle. It then checks that the latch holds the freshly written byte merged with the old other half, and not the value staged before the write. The held-low mode is judged the same way after each single byte, and the half-written code it exposes is expected there.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int N_CH   = 4;
  localparam int CODE_W = 14;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
endpackage

// File: rtl/dac_bank_dec.sv
module dac_bank_dec #(
  parameter int N_CH   = dac_bank_pkg::N_CH,
  parameter int ADDR_W = dac_bank_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CH-1:0]   sel_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic bcast;
  assign bcast = addr_i[ADDR_W-1];

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign sel_o[i] = bcast | (addr_i[IDX_W-1:0] == IDX_W'(i));
  end
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan #(
  parameter int CODE_W = dac_bank_pkg::CODE_W,
  parameter int BYTE_W = dac_bank_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              load_i,
  output logic [CODE_W-1:0] in_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int HI_W = CODE_W - BYTE_W;

  logic [CODE_W-1:0] in_q, in_d, lat_q;

  always_comb begin
    in_d = in_q;
    if (we_i) begin
      if (hi_i) in_d[CODE_W-1:BYTE_W] = data_i[HI_W-1:0];
      else      in_d[BYTE_W-1:0]      = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      lat_q <= '0;
    end else begin
      in_q <= in_d;
      // load sees this edge's write
      if (load_i) lat_q <= in_d;
    end
  end

  assign in_o   = in_q;
  assign code_o = lat_q;
endmodule

// File: rtl/dac_bank.sv
module dac_bank #(
  parameter int N_CH   = dac_bank_pkg::N_CH,
  parameter int CODE_W = dac_bank_pkg::CODE_W,
  parameter int BYTE_W = dac_bank_pkg::BYTE_W,
  parameter int ADDR_W = dac_bank_pkg::ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     hi_byte_i,
  input  logic [BYTE_W-1:0]        data_i,
  input  logic                     ldac_ni,
  output logic [N_CH*CODE_W-1:0]   code_o
);
  logic              wr_q, wr_go;
  logic [N_CH-1:0]   sel;
  logic [N_CH*CODE_W-1:0] in_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign wr_go = wr_i & ~wr_q & ~cs_ni;

  dac_bank_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    dac_bank_chan #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_go & sel[i]),
      .hi_i   (hi_byte_i),
      .data_i (data_i),
      .load_i (~ldac_ni),
      .in_o   (in_flat[i*CODE_W +: CODE_W]),
      .code_o (code_o[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int N_CH   = dac_bank_pkg::N_CH,
  parameter int CODE_W = dac_bank_pkg::CODE_W,
  parameter int BYTE_W = dac_bank_pkg::BYTE_W,
  parameter int ADDR_W = dac_bank_pkg::ADDR_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   wr_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   hi_byte_i,
  input logic [BYTE_W-1:0]      data_i,
  input logic                   ldac_ni,
  input logic [N_CH*CODE_W-1:0] in_flat,
  input logic [N_CH*CODE_W-1:0] code_o
);
  logic wr_seen;
  logic [BYTE_W-1:0] lo0;
  logic lo_same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_seen <= 1'b0;
    else         wr_seen <= wr_i;
  end

  assign lo0 = in_flat[BYTE_W-1:0];
  always_comb begin
    lo_same = 1'b1;
    for (int i = 1; i < N_CH; i++)
      if (in_flat[i*CODE_W +: BYTE_W] != lo0) lo_same = 1'b0;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldac_ni |=> $stable(code_o)); // R6

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_ni |=> (code_o == in_flat)); // R7

  AST_CS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(in_flat)); // R5

  AST_BCAST_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_seen && !cs_ni && addr_i[ADDR_W-1] && !hi_byte_i)
      |=> (lo_same && lo0 == $past(data_i))); // R3
endmodule

bind dac_bank dac_bank_chk #(
  .N_CH(N_CH), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .hi_byte_i (hi_byte_i),
  .data_i    (data_i),
  .ldac_ni   (ldac_ni),
  .in_flat   (in_flat),
  .code_o    (code_o)
);

// File: tb/dac_bank_tb_top.sv
module dac_bank_tb_top;
  localparam int NC = 4;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic hi_byte_i = 1'b0;
  logic [7:0] data_i = '0;
  logic ldac_ni = 1'b1;
  logic [NC*CW-1:0] code_o;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] exp_in [NC];
  logic [CW-1:0] exp_lat [NC];

  always #10 clk = ~clk;

  dac_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_i(wr_i),
    .addr_i(addr_i), .hi_byte_i(hi_byte_i), .data_i(data_i),
    .ldac_ni(ldac_ni), .code_o(code_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int ch, input logic [CW-1:0] exp);
    total++;
    if (code_o[ch*CW +: CW] !== exp) begin
      bad++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, code_o[ch*CW +: CW], exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < NC; c++) chk(req, c, exp_lat[c]);
  endtask

  task automatic model_wr(input logic [2:0] a, input logic hi, input logic [7:0] d);
    for (int c = 0; c < NC; c++)
      if (a[2] || a[1:0] == 2'(c)) begin
        if (hi) exp_in[c][13:8] = d[5:0];
        else    exp_in[c][7:0]  = d;
        if (!ldac_ni) exp_lat[c] = exp_in[c];
      end
  endtask

  task automatic wr(input logic [2:0] a, input logic hi, input logic [7:0] d);
    cs_ni = 1'b0; addr_i = a; hi_byte_i = hi; data_i = d; wr_i = 1'b1;
    step();
    model_wr(a, hi, d);
    wr_i = 1'b0; cs_ni = 1'b1;
    step();
  endtask

  task automatic pulse();
    ldac_ni = 1'b0;
    step();
    ldac_ni = 1'b1;
    for (int c = 0; c < NC; c++) exp_lat[c] = exp_in[c];
    step();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int c = 0; c < NC; c++) begin exp_in[c] = '0; exp_lat[c] = '0; end
    step();
    chk_all("R1 in reset");
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_reset();
    step();
    chk_all("R1 after reset");
    pulse();
    chk_all("R1 staged zero");
  endtask

  task automatic t_select();
    wr(3'b000, 1'b0, 8'h11); wr(3'b000, 1'b1, 8'h01);
    wr(3'b001, 1'b0, 8'h22); wr(3'b001, 1'b1, 8'h02);
    wr(3'b010, 1'b0, 8'h33); wr(3'b010, 1'b1, 8'h03);
    wr(3'b011, 1'b0, 8'h44); wr(3'b011, 1'b1, 8'h04);
    chk_all("R6 hold during writes");
    pulse();
    chk_all("R2 R7 per-channel select");
    chk(R10_tag(), 2, 14'h0333);
  endtask

  function automatic string R10_tag();
    return "R10 field position";
  endfunction

  task automatic t_bcast();
    wr(3'b110, 1'b0, 8'hA5);
    wr(3'b101, 1'b1, 8'h2C);
    pulse();
    chk_all("R3 broadcast");
    chk("R3 broadcast value", 3, 14'h2CA5);
  endtask

  task automatic t_bytes();
    wr(3'b001, 1'b1, 8'hFF);
    wr(3'b001, 1'b0, 8'h00);
    pulse();
    chk("R4 high byte top bits ignored", 1, 14'h3F00);
    wr(3'b001, 1'b1, 8'hC5);
    pulse();
    chk("R4 high byte keeps low", 1, 14'h0500);
  endtask

  task automatic t_strobe();
    // chip select high: ignored
    cs_ni = 1'b1; addr_i = 3'b000; hi_byte_i = 1'b0; data_i = 8'h99; wr_i = 1'b1;
    step(); wr_i = 1'b0; step();
    pulse();
    chk("R5 cs high ignored", 0, exp_lat[0]);
    // strobe held high: one write only
    cs_ni = 1'b0; addr_i = 3'b010; hi_byte_i = 1'b0; data_i = 8'h5E; wr_i = 1'b1;
    step();
    model_wr(3'b010, 1'b0, 8'h5E);
    data_i = 8'h77;
    step(); step();
    wr_i = 1'b0; cs_ni = 1'b1;
    step();
    pulse();
    chk("R5 held strobe single write", 2, exp_in[2]);
  endtask

  task automatic t_transparent();
    ldac_ni = 1'b0;
    step();
    for (int c = 0; c < NC; c++) exp_lat[c] = exp_in[c];
    wr(3'b011, 1'b0, 8'h6B);
    chk("R8 intermediate after first byte", 3, {exp_in[3][13:8], 8'h6B});
    wr(3'b011, 1'b1, 8'h15);
    chk("R8 follows second byte", 3, 14'h156B);
    ldac_ni = 1'b1;
    step();
    wr(3'b011, 1'b0, 8'h00);
    chk("R6 hold after release", 3, 14'h156B);
  endtask

  task automatic t_coincide();
    pulse();
    cs_ni = 1'b0; addr_i = 3'b000; hi_byte_i = 1'b0; data_i = 8'hC3; wr_i = 1'b1;
    ldac_ni = 1'b0;
    step();
    model_wr(3'b000, 1'b0, 8'hC3);
    for (int c = 0; c < NC; c++) exp_lat[c] = exp_in[c];
    wr_i = 1'b0; cs_ni = 1'b1; ldac_ni = 1'b1;
    step();
    chk("R9 load with same-edge write", 0, {exp_in[0][13:8], 8'hC3});
    chk_all("R7 R9 coincident load");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin exp_in[c] = '0; exp_lat[c] = '0; end
    step(); step();
    do_reset();
    t_reset();
    t_select();
    t_bcast();
    t_bytes();
    t_strobe();
    t_transparent();
    t_coincide();
    do_reset();
    chk_all("R1 mid-run reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule